// File: doc/BRIEF.md
# Lockable Copy-Back Set-Associative Data Cache

This block is a four-way set-associative data cache that keeps stores inside the cache (copy-back) until a line has to leave. Every way of every set carries a tag, a valid bit, a dirty bit and a lock bit. A locked way is excluded from replacement, so software can pin up to four lines of one set at once. When every way of a set is pinned, a miss to that set does not allocate. A store goes directly to memory as a single word, and a load reads a single word from memory.

The CPU side takes one request at a time with a valid/ready handshake. It carries an operation code, a word address and write data, and it offers read, write, lock, unlock and invalidate. The memory side moves one word per request/acknowledge exchange. It serves line fills, write-backs of dirty victims and single-word bypass traffic. Invalidate discards dirty data on purpose, so a later read sees whatever memory held before.

Top module: `lockable_cache`

## Requirements
- R1: A read (cpuOp 0) of a resident word returns the stored data. A read miss fetches the whole four-word line with four memory reads and then returns the word. The other opcodes are write 1, lock 2, unlock 3 and invalidate 4.
- R2: A write (cpuOp 1) that hits updates only the cached word and marks the line dirty. It causes no memory write.
- R3: Four lines whose byte addresses differ by 0x2000 share one set and can all be resident and locked together. Reads of all four then cause no memory traffic.
- R4: Lock (cpuOp 2) of an absent line fills it and then sets its lock bit. Lock of a resident line completes in the cycle it is presented.
- R5: A locked way is never selected as a replacement victim.
- R6: When all four ways of the addressed set are locked, a write miss performs exactly one memory write and a read miss exactly one memory read. Neither allocates a line.
- R7: Invalidate (cpuOp 4) of a resident line clears its valid, dirty and lock bits without any write-back. A later read returns the older memory contents.
- R8: Unlock (cpuOp 3) clears the lock bit. The line stays valid and dirty and reads hit without memory traffic.
- R9: A dirty victim is written back as four memory writes before the replacement fill. A clean victim is replaced with no memory write.
- R10: The victim is the lowest-numbered invalid way if there is one. Otherwise it is the first unlocked way at or after a per-set pointer. The pointer is set to the way after each newly filled way.
- R11: Read and write hits, and unlock or invalidate of any address, raise cpuReady in the first cycle of the request with no memory traffic.
- R12: memReq is low out of reset. Once raised, it stays high with memWe and the beat position stable until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU request present, held until cpuReady |
| cpuOp | input | 3 | Operation: 0 read, 1 write, 2 lock, 3 unlock, 4 invalidate |
| cpuAddr | input | ADDR_W (18) | Word address of the request |
| cpuWData | input | DATA_W (32) | Store data |
| cpuReady | output | 1 | Request completes in this cycle |
| cpuRData | output | DATA_W (32) | Load data, valid with cpuReady on a read |
| memReq | output | 1 | Memory word transfer requested |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | ADDR_W (18) | Word address of the transfer |
| memWData | output | DATA_W (32) | Write data of the transfer |
| memAck | input | 1 | Transfer accepted; read data valid |
| memRData | input | DATA_W (32) | Read data returned with memAck |

## Verification
The lookup that decides hit or miss reads the same lock bits that a lock or unlock hit writes, and it picks a victim from them in that same cycle. The bench pins one way of a set and at once issues a miss whose round-robin pointer rests on that pinned way. It also unlocks one way of a fully pinned set and follows with a miss to the same set. Which line was displaced is judged only at the ports: the memory read and write counts of later accesses show whether each line still hits, and the values written back are checked against the bench memory.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_LOCK   = 3'd2,
    OP_UNLOCK = 3'd3,
    OP_INVAL  = 3'd4
  } cacheOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrWord;   // store into hit way, mark dirty
    logic setLock;  // set lock bit of hit way
    logic clrLock;  // clear lock bit of hit way
    logic inval;    // drop hit way
    logic fillWord; // write memory word into chosen way
    logic install;  // commit tag, valid, clean; move pointer
    logic selWb;    // memory address from chosen way's tag
    logic selByp;   // memory address/data straight from CPU
    logic rdMem;    // CPU read data from memory
  } dpCtl_t;
endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int WAYS = 4,
  parameter int SETS = 8,
  parameter int LINE_WORDS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int WRD_W = $clog2(LINE_WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - WRD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  input  logic [WAY_W-1:0]  way,
  input  logic [WRD_W-1:0]  wordSel,
  input  logic [DATA_W-1:0] memRData,
  output logic              hit,
  output logic              allLocked,
  output logic [WAY_W-1:0]  victimWay,
  output logic              victimDirty,
  output logic [DATA_W-1:0] cpuRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData
);
  logic [TAG_W-1:0]  tagQ  [SETS][WAYS];
  logic [DATA_W-1:0] dataQ [SETS][WAYS][LINE_WORDS];
  logic [WAYS-1:0]   validQ [SETS];
  logic [WAYS-1:0]   dirtyQ [SETS];
  logic [WAYS-1:0]   lockQ  [SETS];
  logic [WAY_W-1:0]  rrQ    [SETS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] tagIn;
  logic [WRD_W-1:0] wordIdx;
  logic [WAY_W-1:0] hitWay;
  logic             found;
  logic [WAY_W-1:0] cand;

  assign wordIdx = cpuAddr[WRD_W-1:0];
  assign setIdx  = cpuAddr[WRD_W +: IDX_W];
  assign tagIn   = cpuAddr[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit = 1'b0;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (validQ[setIdx][w] && tagQ[setIdx][w] == tagIn) begin
        hit = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  assign allLocked = &lockQ[setIdx];

  // Victim: lowest invalid way, else round robin skipping locked ways
  always_comb begin
    victimWay = '0;
    found = 1'b0;
    cand = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !validQ[setIdx][w]) begin
        victimWay = WAY_W'(w);
        found = 1'b1;
      end
    end
    for (int k = 0; k < WAYS; k++) begin
      cand = rrQ[setIdx] + WAY_W'(k);
      if (!found && !lockQ[setIdx][cand]) begin
        victimWay = cand;
        found = 1'b1;
      end
    end
  end

  assign victimDirty = validQ[setIdx][victimWay] & dirtyQ[setIdx][victimWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
        lockQ[s]  <= '0;
        rrQ[s]    <= '0;
      end
    end else begin
      if (ctl.wrWord)  dirtyQ[setIdx][hitWay] <= 1'b1;
      if (ctl.setLock) lockQ[setIdx][hitWay]  <= 1'b1;
      if (ctl.clrLock) lockQ[setIdx][hitWay]  <= 1'b0;
      if (ctl.inval) begin
        validQ[setIdx][hitWay] <= 1'b0;
        dirtyQ[setIdx][hitWay] <= 1'b0;
        lockQ[setIdx][hitWay]  <= 1'b0;
      end
      if (ctl.install) begin
        validQ[setIdx][way] <= 1'b1;
        dirtyQ[setIdx][way] <= 1'b0;
        rrQ[setIdx]         <= way + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.install)  tagQ[setIdx][way] <= tagIn;
    if (ctl.wrWord)   dataQ[setIdx][hitWay][wordIdx] <= cpuWData;
    if (ctl.fillWord) dataQ[setIdx][way][wordSel] <= memRData;
  end

  always_comb begin
    if (ctl.selByp)     memAddr = cpuAddr;
    else if (ctl.selWb) memAddr = {tagQ[setIdx][way], setIdx, wordSel};
    else                memAddr = {tagIn, setIdx, wordSel};
  end

  assign memWData = ctl.selByp ? cpuWData : dataQ[setIdx][way][wordSel];
  assign cpuRData = ctl.rdMem ? memRData : dataQ[setIdx][hitWay][wordIdx];

  // R5: a way being refilled is never a locked one
  p_fill_unlocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillWord |-> !lockQ[setIdx][way]);

  // R2: a cached store only happens on a tag match
  p_store_on_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrWord |-> hit);
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl
  import cache_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int LINE_WORDS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int WRD_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuValid,
  input  cacheOp_e         cpuOp,
  input  logic             hit,
  input  logic             allLocked,
  input  logic [WAY_W-1:0] victimWay,
  input  logic             victimDirty,
  input  logic             memAck,
  output dpCtl_t           ctl,
  output logic             cpuReady,
  output logic             memReq,
  output logic             memWe,
  output logic [WAY_W-1:0] way,
  output logic [WRD_W-1:0] wordSel
);
  typedef enum logic [2:0] {S_IDLE, S_WBACK, S_FILL, S_BYP_WR, S_BYP_RD} state_e;
  localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(LINE_WORDS - 1);

  state_e stateQ, stateD;
  logic   missGo;

  always_comb begin
    ctl = '0;
    cpuReady = 1'b0;
    missGo = 1'b0;
    stateD = stateQ;
    ctl.selWb  = (stateQ == S_WBACK);
    ctl.selByp = (stateQ == S_BYP_WR) || (stateQ == S_BYP_RD);
    ctl.rdMem  = (stateQ == S_BYP_RD);
    unique case (stateQ)
      S_IDLE: if (cpuValid) begin
        unique case (cpuOp)
          OP_READ: begin
            if (hit) cpuReady = 1'b1;
            else if (allLocked) stateD = S_BYP_RD;
            else missGo = 1'b1;
          end
          OP_WRITE: begin
            if (hit) begin cpuReady = 1'b1; ctl.wrWord = 1'b1; end
            else if (allLocked) stateD = S_BYP_WR;
            else missGo = 1'b1;
          end
          OP_LOCK: begin
            if (hit) begin cpuReady = 1'b1; ctl.setLock = 1'b1; end
            else if (allLocked) cpuReady = 1'b1;
            else missGo = 1'b1;
          end
          OP_UNLOCK: begin cpuReady = 1'b1; ctl.clrLock = hit; end
          OP_INVAL:  begin cpuReady = 1'b1; ctl.inval = hit; end
          default:   cpuReady = 1'b1;
        endcase
        if (missGo) stateD = victimDirty ? S_WBACK : S_FILL;
      end
      S_WBACK: if (memAck && wordSel == LAST_WORD) stateD = S_FILL;
      S_FILL: begin
        ctl.fillWord = memAck;
        if (memAck && wordSel == LAST_WORD) begin
          ctl.install = 1'b1;
          stateD = S_IDLE;
        end
      end
      S_BYP_WR, S_BYP_RD: if (memAck) begin
        cpuReady = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      way     <= '0;
      wordSel <= '0;
    end else begin
      stateQ <= stateD;
      if (missGo) begin
        way     <= victimWay;
        wordSel <= '0;
      end else if (memAck && (stateQ == S_WBACK || stateQ == S_FILL)) begin
        wordSel <= wordSel + WRD_W'(1);
      end
    end
  end

  assign memReq = (stateQ != S_IDLE);
  assign memWe  = (stateQ == S_WBACK) || (stateQ == S_BYP_WR);

  // R12: an unanswered memory request is held unchanged
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(wordSel));

  // R11: completion is only signalled against a live request
  p_ready_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid);

  // R7: invalidate never starts memory traffic
  p_inval_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == S_IDLE && cpuValid && cpuOp == OP_INVAL |=> !memReq);

  // R6: a bypass store is one beat and then the port goes idle
  p_bypass_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == S_BYP_WR && memAck |=> !memReq);
endmodule

// File: rtl/lockable_cache.sv
module lockable_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int WAYS = 4,
  parameter int SETS = 8,
  parameter int LINE_WORDS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int WRD_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic [2:0]        cpuOp,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRData
);
  dpCtl_t           ctl;
  logic             hit, allLocked, victimDirty;
  logic [WAY_W-1:0] victimWay, way;
  logic [WRD_W-1:0] wordSel;

  cache_ctl #(.WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuOp(cacheOp_e'(cpuOp)),
    .hit(hit), .allLocked(allLocked), .victimWay(victimWay),
    .victimDirty(victimDirty), .memAck(memAck), .ctl(ctl),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
    .way(way), .wordSel(wordSel)
  );

  cache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS),
             .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .way(way), .wordSel(wordSel), .memRData(memRData), .hit(hit),
    .allLocked(allLocked), .victimWay(victimWay), .victimDirty(victimDirty),
    .cpuRData(cpuRData), .memAddr(memAddr), .memWData(memWData)
  );
endmodule

// File: tb/sim_lockable_cache.sv
module sim_lockable_cache;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, LK = 3'd2, UL = 3'd3, IV = 3'd4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0;
  logic [2:0]  cpuOp = RD;
  logic [17:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic        cpuReady;
  logic [31:0] cpuRData;
  logic        memReq, memWe;
  logic [17:0] memAddr;
  logic [31:0] memWData;
  logic        memAck = 1'b0;
  logic [31:0] memRData = '0;

  int nChecks = 0;
  int nFails = 0;
  int rdCount = 0;
  int wrCount = 0;
  logic [31:0] mem [logic [17:0]];

  logic [31:0] expQ [$];
  string       tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lockable_cache u0 (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuOp(cpuOp),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .cpuReady(cpuReady),
    .cpuRData(cpuRData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memAck(memAck), .memRData(memRData)
  );

  // Memory model: one word per exchange, ack one cycle after request
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr] = memWData;
        wrCount = wrCount + 1;
      end else begin
        memRData <= mem.exists(memAddr) ? mem[memAddr] : 32'h0;
        rdCount = rdCount + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as each read completes
  always begin
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    if (cpuValid && cpuReady && cpuOp == RD) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected read", cpuRData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(cpuRData === e, t, cpuRData, e);
      end
    end
  end

  int cyc;
  int rd0, wr0;

  // Driver: issues one request and waits for its completion
  task automatic access(input logic [2:0] op, input logic [31:0] byteAddr,
                        input logic [31:0] wdata, input logic [31:0] exp,
                        input string tag);
    @(negedge clk);
    rd0 = rdCount;
    wr0 = wrCount;
    cpuValid = 1'b1;
    cpuOp = op;
    cpuAddr = byteAddr[19:2];
    cpuWData = wdata;
    if (op == RD) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    cyc = 0;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  task automatic traffic(input string tag, input int dRd, input int dWr);
    check(rdCount - rd0 == dRd, {tag, " memory reads"}, 32'(rdCount - rd0), 32'(dRd));
    check(wrCount - wr0 == dWr, {tag, " memory writes"}, 32'(wrCount - wr0), 32'(dWr));
  endtask

  function automatic logic [31:0] aAddr(input int i);
    return 32'h70000 + 32'(i) * 32'h2000;
  endfunction
  function automatic logic [31:0] bAddr(input int i);
    return 32'h10 + 32'(i) * 32'h2000;
  endfunction
  function automatic logic [31:0] bData(input int i);
    return 32'hB0B0_0000 + 32'(i);
  endfunction

  localparam logic [31:0] VALS [4] = '{32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) mem[bAddr(i) >> 2] = bData(i);
    repeat (3) @(negedge clk);
    check(cpuReady == 1'b0, "R12 reset cpuReady", 32'(cpuReady), 0);
    check(memReq == 1'b0, "R12 reset memReq", 32'(memReq), 0);
    rstN = 1'b1;

    // R4/R2/R3: pin four lines of one set
    for (int i = 0; i < 4; i++) begin
      access(LK, aAddr(i), 0, 0, "R4");
      traffic("R4 lock fill", 4, 0);
      access(WR, aAddr(i), VALS[i], 0, "R2");
      traffic("R2 write hit", 0, 0);
      check(cyc == 0, "R11 write hit latency", 32'(cyc), 0);
    end
    for (int i = 0; i < 4; i++) begin
      access(RD, aAddr(i), 0, VALS[i], "R3 read pinned line");
      traffic("R3 pinned hit", 0, 0);
    end

    // R6: bypass when every way is pinned
    access(WR, aAddr(4), 32'hDEADBEEF, 0, "R6");
    traffic("R6 bypass write", 0, 1);
    check(mem[aAddr(4) >> 2] == 32'hDEADBEEF, "R6 memory word", mem[aAddr(4) >> 2], 32'hDEADBEEF);
    access(RD, aAddr(4), 0, 32'hDEADBEEF, "R6 bypass read data");
    traffic("R6 bypass read", 1, 0);

    // R7: invalidate drops dirty data
    for (int i = 0; i < 4; i++) begin
      access(IV, aAddr(i), 0, 0, "R7");
      traffic("R7 invalidate", 0, 0);
    end
    for (int i = 0; i < 4; i++) begin
      access(RD, aAddr(i), 0, 32'h0, "R7 old memory value");
      traffic("R1 refill after invalidate", 4, 0);
    end

    // R11: maintenance on non-resident line
    access(IV, 32'h7C000, 0, 0, "R11");
    check(cyc == 0, "R11 invalidate miss latency", 32'(cyc), 0);
    traffic("R11 invalidate miss", 0, 0);
    access(UL, 32'h7C000, 0, 0, "R11");
    check(cyc == 0, "R11 unlock miss latency", 32'(cyc), 0);
    traffic("R11 unlock miss", 0, 0);

    // Pin again (resident now) and dirty
    for (int i = 0; i < 4; i++) begin
      access(LK, aAddr(i), 0, 0, "R4");
      check(cyc == 0, "R4 lock hit latency", 32'(cyc), 0);
      traffic("R4 lock hit", 0, 0);
      access(WR, aAddr(i), VALS[i], 0, "R2");
    end

    // R8: unlock keeps line
    access(UL, aAddr(1), 0, 0, "R8");
    access(RD, aAddr(1), 0, VALS[1], "R8 unlocked line data");
    traffic("R8 unlocked line hit", 0, 0);

    // R9/R5: miss evicts the only unpinned (dirty) way
    access(WR, aAddr(5), 32'hBEEFDEAD, 0, "R9");
    traffic("R9 dirty eviction", 4, 4);
    check(mem[aAddr(1) >> 2] == VALS[1], "R9 written-back data", mem[aAddr(1) >> 2], VALS[1]);
    for (int i = 0; i < 4; i++) begin
      if (i != 1) begin
        access(RD, aAddr(i), 0, VALS[i], "R5 pinned data");
        traffic("R5 pinned line kept", 0, 0);
      end
    end
    access(RD, aAddr(1), 0, VALS[1], "R9 refetched data");
    traffic("R9 second eviction", 4, 4);
    access(RD, aAddr(5), 0, 32'hBEEFDEAD, "R9 written-back store");
    traffic("R9 clean victim", 4, 0);
    access(RD, aAddr(4), 0, 32'hDEADBEEF, "R6 bypass data kept");

    // R10: round robin in another set
    for (int i = 0; i < 4; i++) access(RD, bAddr(i), 0, bData(i), "R10 fill invalid ways");
    access(RD, bAddr(4), 0, bData(4), "R10");
    traffic("R10 clean eviction", 4, 0);
    access(RD, bAddr(5), 0, bData(5), "R10");
    access(RD, bAddr(2), 0, bData(2), "R10");
    traffic("R10 way 2 kept", 0, 0);
    access(RD, bAddr(3), 0, bData(3), "R10");
    traffic("R10 way 3 kept", 0, 0);
    access(RD, bAddr(0), 0, bData(0), "R10");
    traffic("R10 way 0 was evicted", 4, 0);
    access(RD, bAddr(1), 0, bData(1), "R10");
    traffic("R10 way 1 was evicted", 4, 0);
    // now: w0=B4 w1=B5 w2=B0 w3=B1, pointer at 0
    access(LK, bAddr(4), 0, 0, "R5");
    access(RD, bAddr(2), 0, bData(2), "R10");
    traffic("R10 miss past pinned way", 4, 0);
    access(RD, bAddr(4), 0, bData(4), "R5");
    traffic("R5 pinned way skipped", 0, 0);
    access(RD, bAddr(5), 0, bData(5), "R10");
    traffic("R10 next unpinned way evicted", 4, 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1 all reads completed", 32'(expQ.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule